// File: doc/BRIEF.md
# Word-Serial AES Encryption Engine

This block enciphers one 128-bit block at a time with AES, using 128-bit or 256-bit keys. It is iterative: a single block is held in a state register and carried through all rounds before the engine accepts another one. Byte substitution runs one 32-bit column per cycle through a bank of four 8-bit S-boxes. The remaining round steps (row shifting, column mixing and round-key addition) then act on the whole state in one further cycle. Each round therefore takes five cycles.

The engine does not expand keys. It drives a round index, and an external round-key store answers in the same cycle with the 128-bit key for that round. The S-box bank is also exposed through a shared substitution port, so that a neighbouring key-expansion unit can substitute words while the engine is idle. That unit raises a busy input while it works, and the engine refuses to start during that time.

Top module: `aes_word_enc`

## Requirements
- R1: While reset is held and after it is released, `ready_o` is 1, `rk_idx_o` is 0 and `result_o` is all zeros.
- R2: With `key_len_i` = 0 (128-bit key), the result equals the AES-128 ciphertext of `block_i` under the supplied round keys. `ready_o` returns to 1 exactly 50 rising edges after the edge that accepted the start.
- R3: With `key_len_i` = 1 (256-bit key), the result equals the AES-256 ciphertext. `ready_o` returns to 1 exactly 70 rising edges after the accepting edge.
- R4: `rk_idx_o` is 0 whenever the engine is idle, and that round key is used for the initial key addition. In the cycles between edges 5(r-1) and 5r after the accepting edge, it equals round number r. It counts up by one per round only.
- R5: An accepted start drives `ready_o` to 0 from the next cycle until the result is valid. While `ready_o` stays 1, `result_o` holds its value.
- R6: A start strobe that arrives while `ready_o` is 0 is ignored, even if it carries a different block or key length. The running block's result and latency are unchanged.
- R7: A start strobe that arrives while `kx_busy_i` is 1 is ignored: `ready_o` stays 1, `rk_idx_o` stays 0 and `result_o` is unchanged.
- R8: While idle, `kx_sb_out_o` equals the AES forward S-box applied to each byte of `kx_sb_in_i` within the same cycle. Using this port does not change `result_o`.
- R9: The key length is sampled only at the accepting edge. The round index never exceeds 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle and key expansion is not busy |
| key_len_i | input | 1 | 0 selects 128-bit key (10 rounds), 1 selects 256-bit key (14 rounds) |
| block_i | input | 128 | Plaintext block, first byte in bits 127:120 |
| rk_i | input | 128 | Round key for index `rk_idx_o`, same byte order as the block |
| rk_idx_o | output | 4 | Round index addressing the round-key store |
| result_o | output | 128 | Ciphertext, valid while `ready_o` is 1 |
| ready_o | output | 1 | 1 when idle with a valid result |
| kx_busy_i | input | 1 | Key expansion owns the S-box bank; start is blocked |
| kx_sb_in_i | input | 32 | Word to substitute for the key-expansion unit |
| kx_sb_out_o | output | 32 | Byte-wise S-box of `kx_sb_in_i` while idle |

## Verification
The shared substitution port is combinational, so the bench samples `kx_sb_out_o` one time step after it changes the input. It sweeps all 256 byte values against an S-box that the bench builds from a brute-force field inverse. After the accepting edge, the bench counts rising edges and samples one time step after each edge. There it compares the round index with the round number implied by the edge count (five edges per round). It expects `ready_o` and the ciphertext after exactly edge 50 or edge 70. The ciphertexts are checked against the published single-block vectors and against a byte-level model in the bench. A start poked in the middle of a run must leave that edge count and the ciphertext unchanged.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

    localparam int BLK_W    = 128;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int NCOL     = BLK_W / WORD_W;
    localparam int NLANE    = WORD_W / BYTE_W;
    localparam int COL_W    = $clog2(NCOL);
    localparam int IDX_W    = 4;
    localparam int NR_SHORT = 10;
    localparam int NR_LONG  = 14;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  block_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SUB  = 2'd1,
        PH_MIX  = 2'd2
    } phase_e;

    typedef enum logic {
        KL_128 = 1'b0,
        KL_256 = 1'b1
    } keylen_e;

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] round;
        logic [COL_W-1:0] col;
        logic [IDX_W-1:0] last;
    } ctrl_t;

    function automatic byte_t gf_x2(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (zero maps to zero), then affine map.
    function automatic byte_t sbox_calc(input byte_t a);
        byte_t      r   = 8'h01;
        byte_t      sq  = a;
        logic [7:0] e   = 8'd254;
        byte_t      s;
        for (int i = 0; i < BYTE_W; i++) begin
            if (e[i]) r = gf_mul(r, sq);
            sq = gf_mul(sq, sq);
        end
        s = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
              ^ {r[3:0], r[7:4]} ^ 8'h63;
        return s;
    endfunction

    function automatic byte_t get_byte(input block_t b, input int col, input int row);
        return b[BLK_W-1-WORD_W*col-BYTE_W*row -: BYTE_W];
    endfunction

    function automatic word_t get_col(input block_t b, input int col);
        return b[BLK_W-1-WORD_W*col -: WORD_W];
    endfunction

    function automatic word_t mix_column(input word_t w);
        byte_t a0 = w[31:24];
        byte_t a1 = w[23:16];
        byte_t a2 = w[15:8];
        byte_t a3 = w[7:0];
        byte_t b0 = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
        byte_t b1 = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
        byte_t b2 = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
        byte_t b3 = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
        return {b0, b1, b2, b3};
    endfunction

    // Row r of output column c takes row r of input column (c + r) mod NCOL.
    function automatic word_t shifted_col(input block_t b, input int col);
        word_t w;
        for (int r = 0; r < NLANE; r++)
            w[WORD_W-1-BYTE_W*r -: BYTE_W] = get_byte(b, (col + r) % NCOL, r);
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] rounds_for(input keylen_e kl);
        return (kl == KL_256) ? IDX_W'(NR_LONG) : IDX_W'(NR_SHORT);
    endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_enc_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    always_comb dout = sbox_calc(din);
endmodule

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank
    import aes_enc_pkg::*;
#(
    parameter int LANES = NLANE
) (
    input  logic [LANES*BYTE_W-1:0] word_in,
    output logic [LANES*BYTE_W-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        aes_sbox u_sb (
            .din  (word_in [BYTE_W*g +: BYTE_W]),
            .dout (word_out[BYTE_W*g +: BYTE_W])
        );
    end
endmodule

// File: rtl/aes_round_mix.sv
module aes_round_mix
    import aes_enc_pkg::*;
(
    input  logic [BLK_W-1:0] state_in,
    input  logic [BLK_W-1:0] round_key,
    input  logic             skip_mix,
    output logic [BLK_W-1:0] state_out
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        word_t rowed;
        word_t mixed;
        always_comb begin
            rowed = shifted_col(state_in, c);
            mixed = skip_mix ? rowed : mix_column(rowed);
            state_out[BLK_W-1-WORD_W*c -: WORD_W] = mixed ^ get_col(round_key, c);
        end
    end
endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
    import aes_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             long_key,
    input  logic             kx_busy,
    output logic             accept,
    output logic             sub_en,
    output logic             mix_en,
    output logic             final_round,
    output logic             idle,
    output logic [COL_W-1:0] col,
    output logic [IDX_W-1:0] round
);
    ctrl_t q, d;

    always_comb begin
        idle        = (q.phase == PH_IDLE);
        accept      = idle && start && !kx_busy;
        sub_en      = (q.phase == PH_SUB);
        mix_en      = (q.phase == PH_MIX);
        final_round = (q.round == q.last);
        col         = q.col;
        round       = q.round;

        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (accept) begin
                    d.phase = PH_SUB;
                    d.round = IDX_W'(1);
                    d.col   = '0;
                    d.last  = rounds_for(keylen_e'(long_key));
                end
            end
            PH_SUB: begin
                d.col = q.col + COL_W'(1);
                if (q.col == COL_W'(NCOL - 1)) d.phase = PH_MIX;
            end
            PH_MIX: begin
                if (final_round) begin
                    d.phase = PH_IDLE;
                    d.round = '0;
                end else begin
                    d.phase = PH_SUB;
                    d.round = q.round + IDX_W'(1);
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.phase <= PH_IDLE;
            q.round <= '0;
            q.col   <= '0;
            q.last  <= IDX_W'(NR_SHORT);
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/aes_word_enc.sv
module aes_word_enc
    import aes_enc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         key_len_i,
    input  logic [127:0] block_i,
    input  logic [127:0] rk_i,
    output logic [3:0]   rk_idx_o,
    output logic [127:0] result_o,
    output logic         ready_o,
    input  logic         kx_busy_i,
    input  logic [31:0]  kx_sb_in_i,
    output logic [31:0]  kx_sb_out_o
);
    logic             accept, sub_en, mix_en, final_round, idle;
    logic [COL_W-1:0] col;
    logic [IDX_W-1:0] round;
    block_t           state_q, state_d, mixed;
    word_t            bank_in, bank_out;

    aes_enc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start_i),
        .long_key    (key_len_i),
        .kx_busy     (kx_busy_i),
        .accept      (accept),
        .sub_en      (sub_en),
        .mix_en      (mix_en),
        .final_round (final_round),
        .idle        (idle),
        .col         (col),
        .round       (round)
    );

    // The bank serves the datapath during substitution, the key-expansion port otherwise.
    always_comb begin
        bank_in = kx_sb_in_i;
        if (sub_en) begin
            for (int c = 0; c < NCOL; c++)
                if (col == COL_W'(c)) bank_in = get_col(state_q, c);
        end
    end

    aes_sbox_bank #(.LANES(NLANE)) u_bank (
        .word_in  (bank_in),
        .word_out (bank_out)
    );

    aes_round_mix u_mix (
        .state_in  (state_q),
        .round_key (rk_i),
        .skip_mix  (final_round),
        .state_out (mixed)
    );

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = block_i ^ rk_i;
        end else if (sub_en) begin
            for (int c = 0; c < NCOL; c++)
                if (col == COL_W'(c)) state_d[BLK_W-1-WORD_W*c -: WORD_W] = bank_out;
        end else if (mix_en) begin
            state_d = mixed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rk_idx_o    = round;
    assign result_o    = state_q;
    assign ready_o     = idle;
    assign kx_sb_out_o = bank_out;
endmodule

module aes_word_enc_chk (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         kx_busy_i,
    input logic [3:0]   rk_idx_o,
    input logic [127:0] result_o,
    input logic         ready_o
);
    p_idle_idx_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (rk_idx_o == 4'd0));

    p_idx_steps_r4: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !$past(ready_o)) |->
            (rk_idx_o == $past(rk_idx_o) || rk_idx_o == $past(rk_idx_o) + 4'd1));

    p_start_drops_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i && !kx_busy_i) |=> !ready_o);

    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (ready_o && $past(ready_o)) |-> $stable(result_o));

    p_kx_blocks_start_r7: assert property (@(posedge clk) disable iff (rst)
        (ready_o && kx_busy_i) |=> ready_o);

    p_idx_bound_r9: assert property (@(posedge clk) disable iff (rst)
        rk_idx_o <= 4'd14);
endmodule

bind aes_word_enc aes_word_enc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .kx_busy_i (kx_busy_i),
    .rk_idx_o  (rk_idx_o),
    .result_o  (result_o),
    .ready_o   (ready_o)
);

// File: tb/tb_aes_word_enc.sv
module tb_aes_word_enc;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         key_len_i = 1'b0;
    logic [127:0] block_i = '0;
    logic [127:0] rk_i;
    logic [3:0]   rk_idx_o;
    logic [127:0] result_o;
    logic         ready_o;
    logic         kx_busy_i = 1'b0;
    logic [31:0]  kx_sb_in_i = '0;
    logic [31:0]  kx_sb_out_o;

    logic [127:0] rk_mem [15];
    logic [7:0]   sb_tab [256];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    assign rk_i = rk_mem[rk_idx_o];

    aes_word_enc dut (
        .clk(clk), .rst(rst), .start_i(start_i), .key_len_i(key_len_i),
        .block_i(block_i), .rk_i(rk_i), .rk_idx_o(rk_idx_o), .result_o(result_o),
        .ready_o(ready_o), .kx_busy_i(kx_busy_i), .kx_sb_in_i(kx_sb_in_i),
        .kx_sb_out_o(kx_sb_out_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x = a, y = b, p = 8'h00;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] tdbl(input logic [7:0] a);
        return tmul(a, 8'h02);
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (tmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
            sb_tab[x] = s;
        end
    endtask

    function automatic logic [31:0] tsubw(input logic [31:0] w);
        return {sb_tab[w[31:24]], sb_tab[w[23:16]], sb_tab[w[15:8]], sb_tab[w[7:0]]};
    endfunction

    task automatic expand(input logic [255:0] key, input bit long);
        logic [31:0] w [60];
        logic [7:0]  rc = 8'h01;
        int nk = long ? 8 : 4;
        int nw = long ? 60 : 44;
        for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
        for (int i = nk; i < nw; i++) begin
            logic [31:0] t = w[i-1];
            if (i % nk == 0) begin
                t = tsubw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = tdbl(rc);
            end else if (long && (i % 8 == 4)) begin
                t = tsubw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r < 15; r++)
            rk_mem[r] = (4*r+3 < nw) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input int nr);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [127:0] out;
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk_mem[0][127-8*i -: 8];
        for (int rd = 1; rd <= nr; rd++) begin
            for (int i = 0; i < 16; i++) s[i] = sb_tab[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
            for (int c = 0; c < 4; c++) begin
                logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
                if (rd != nr) begin
                    s[4*c]   = tmul(a0,2) ^ tmul(a1,3) ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ tmul(a1,2) ^ tmul(a2,3) ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ tmul(a2,2) ^ tmul(a3,3);
                    s[4*c+3] = tmul(a0,3) ^ a1 ^ a2 ^ tmul(a3,2);
                end else begin
                    s[4*c] = a0; s[4*c+1] = a1; s[4*c+2] = a2; s[4*c+3] = a3;
                end
            end
            for (int i = 0; i < 16; i++) s[i] ^= rk_mem[rd][127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
        return out;
    endfunction

    // Start a block, follow the round index edge by edge, and check latency and result.
    task automatic run_block(input logic [255:0] key, input bit long, input logic [127:0] pt,
                             input logic [127:0] exp_ct, input bit poke, input string req);
        int k = 0;
        int idx_err = 0;
        int nr = long ? 14 : 10;
        expand(key, long);
        key_len_i = long;
        block_i   = pt;
        start_i   = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        while (!ready_o && k < 200) begin
            if (rk_idx_o != 4'(k/5 + 1)) idx_err++;
            if (poke && k == 17) begin
                start_i = 1'b1; block_i = ~pt; key_len_i = ~long;
            end
            if (poke && k == 18) start_i = 1'b0;
            @(posedge clk); #1;
            k++;
        end
        start_i = 1'b0;
        chk(k == 5*nr, req, "edges until ready", 128'(k), 128'(5*nr));
        chk(idx_err == 0, "R4", "round index mismatches", 128'(idx_err), 128'd0);
        chk(rk_idx_o == 4'd0, "R4", "index after finish", 128'(rk_idx_o), 128'd0);
        chk(result_o == exp_ct, req, "ciphertext", result_o, exp_ct);
        @(posedge clk); #1;
        chk(ready_o && result_o == exp_ct, "R5", "result held while idle", result_o, exp_ct);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] k128a, k128b, k256;
        logic [127:0] held, ct;
        build_sbox();
        for (int r = 0; r < 15; r++) rk_mem[r] = '0;

        repeat (3) @(posedge clk);
        #1;
        chk(ready_o == 1'b1, "R1", "ready in reset", 128'(ready_o), 128'd1);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(ready_o == 1'b1, "R1", "ready after reset", 128'(ready_o), 128'd1);
        chk(rk_idx_o == 4'd0, "R1", "index after reset", 128'(rk_idx_o), 128'd0);
        chk(result_o == '0, "R1", "result after reset", result_o, 128'd0);

        // R8: idle S-box port, full sweep
        chk(sb_tab[8'h53] == 8'hed && sb_tab[8'h00] == 8'h63, "R8", "bench sbox anchor",
            128'({sb_tab[8'h53], sb_tab[8'h00]}), 128'h ed63);
        for (int b = 0; b < 256; b++) begin
            logic [31:0] w = {8'(b), 8'(b) ^ 8'h5a, ~8'(b), 8'(b + 1)};
            kx_sb_in_i = w;
            #1;
            chk(kx_sb_out_o == tsubw(w), "R8", "shared sbox word", 128'(kx_sb_out_o), 128'(tsubw(w)));
        end

        k128a = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
        k128b = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
        k256  = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;

        run_block(k128a, 1'b0, 128'h00112233445566778899aabbccddeeff,
                  128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, "R2");
        run_block(k128b, 1'b0, 128'h3243f6a8885a308d313198a2e0370734,
                  128'h3925841d02dc09fbdc118597196a0b32, 1'b0, "R2");
        run_block(k256, 1'b1, 128'h00112233445566778899aabbccddeeff,
                  128'h8ea2b7ca516745bfeafc49904b496089, 1'b0, "R3");

        // R8: using the port while idle leaves the result alone
        held = result_o;
        for (int b = 0; b < 16; b++) begin
            kx_sb_in_i = {4{8'(b * 17)}};
            @(posedge clk); #1;
        end
        chk(result_o == held, "R8", "result after port use", result_o, held);

        // R6: start mid-run with other block and key length
        run_block(k128a, 1'b0, 128'h00112233445566778899aabbccddeeff,
                  128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1, "R6");
        run_block(k256, 1'b1, 128'h00112233445566778899aabbccddeeff,
                  128'h8ea2b7ca516745bfeafc49904b496089, 1'b1, "R6");

        // R7: start blocked while key expansion is busy
        held = result_o;
        kx_busy_i = 1'b1;
        start_i   = 1'b1;
        block_i   = 128'hdeadbeef;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            chk(ready_o == 1'b1 && rk_idx_o == 4'd0, "R7", "ready while busy",
                128'({ready_o, rk_idx_o}), 128'h10);
        end
        start_i = 1'b0;
        kx_busy_i = 1'b0;
        @(posedge clk); #1;
        chk(result_o == held, "R7", "result after blocked start", result_o, held);

        // R9: key length sampled at start; patterns against the bench model
        for (int p = 0; p < 6; p++) begin
            logic [255:0] key = {8{32'h9e3779b9 * (p + 1)}} ^ 256'(p * 64'h0123_4567_89ab_cdef);
            logic [127:0] pt  = {4{32'h6a09e667 ^ 32'(p * 1103515245)}};
            bit long = p[0];
            expand(key, long);
            ct = ref_enc(pt, long ? 14 : 10);
            run_block(key, long, pt, ct, 1'b0, long ? "R9" : "R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule